// File: doc/BRIEF.md
# Sequential Signed/Unsigned Integer Divider

This block divides one 32-bit integer by another over several clock cycles, producing a quotient and a remainder. A mode input selects whether the operands are treated as two's complement or as plain unsigned values. Both modes run on a single restoring shift-and-subtract datapath. That datapath works on operand magnitudes and settles one quotient bit per cycle. A final cycle then corrects the signs of the results.

The working state is one double-width register. Its upper half accumulates the partial remainder, and its lower half fills up with quotient bits. When the division finishes, the corrected remainder is presented on the high result port and the quotient on the low result port, and a one-cycle completion pulse is given. A zero divisor does not stop the operation or raise a trap. It completes like any other division with a defined result and a flag set, and the consumer decides what to do with it.

A request is accepted only while the block is idle. The results and the zero-divisor flag hold their values until the next operation completes.

Top module: `seq_divider`

## Requirements
- R1: After reset, busy_o, done_o and dz_o are 0, and hi_o and lo_o are all zeros.
- R2: In unsigned mode (signed_i = 0) with a non-zero divisor, the results satisfy dividend = lo_o × divisor + hi_o, with hi_o < divisor.
- R3: In signed mode (signed_i = 1), the quotient is truncated toward zero, so it is negative when exactly one operand is negative (for example 7 / −3 gives −2).
- R4: In signed mode, a non-zero remainder has the sign of the dividend and a magnitude below that of the divisor (for example −7 / 3 gives quotient −2 and remainder −1).
- R5: A start accepted at one rising edge gives done_o = 1 after exactly 33 further rising edges (32 iterations and one sign-correction cycle). busy_o is 1 from the accepting edge until the edge that raises done_o.
- R6: done_o is high for exactly one cycle per completed operation.
- R7: start_i is ignored while busy_o is 1. The running operation completes with its own operands and no extra completion occurs.
- R8: With a zero divisor in either mode, the operation completes with lo_o all ones, hi_o equal to the dividend and dz_o = 1. dz_o is 0 for any non-zero divisor.
- R9: In signed mode, 0x80000000 divided by 0xFFFFFFFF (−1) gives lo_o = 0x80000000, hi_o = 0 and dz_o = 0.
- R10: hi_o, lo_o and dz_o change only on the edge that raises done_o, and otherwise hold their last results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a division; taken only when idle |
| signed_i | input | 1 | 1: two's complement operands, 0: unsigned |
| dividend_i | input | 32 | Dividend, sampled at the accepting edge |
| divisor_i | input | 32 | Divisor, sampled at the accepting edge |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dz_o | output | 1 | Last completed operation had a zero divisor |
| hi_o | output | 32 | Remainder of the last operation |
| lo_o | output | 32 | Quotient of the last operation |

## Verification
Every result appears on the 33rd rising edge after the edge that accepted the start. When the bench issues a request, it records the number of that accepting edge plus 33 as the cycle in which the result is due. The monitor samples on falling edges. When done_o rises, it compares the cycle number, the remainder, the quotient and the flag against the oldest queued expectation. A completion that comes early or late, is missing, is extra, or lasts more than one cycle therefore fails, and this includes a completion triggered by a start issued mid-operation.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_prep.sv
module div_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  input  logic         sgn_i,
  output logic [W-1:0] dvd_mag_o,
  output logic [W-1:0] dvs_mag_o,
  output logic         neg_q_o,
  output logic         neg_r_o
);
  logic dvd_neg, dvs_neg;
  assign dvd_neg   = sgn_i & dvd_i[W-1];
  assign dvs_neg   = sgn_i & dvs_i[W-1];
  assign dvd_mag_o = dvd_neg ? -dvd_i : dvd_i;
  assign dvs_mag_o = dvs_neg ? -dvs_i : dvs_i;
  assign neg_q_o   = dvd_neg ^ dvs_neg;
  assign neg_r_o   = dvd_neg;
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] acc_i,
  input  logic [W-1:0]   dvs_i,
  output logic [2*W-1:0] acc_o
);
  // partial remainder after shift needs W+1 bits; one more for the borrow
  logic [W+1:0] trial;
  logic         borrow;
  assign trial  = {1'b0, acc_i[2*W-1:W-1]} - {2'b00, dvs_i};
  assign borrow = trial[W+1];
  assign acc_o  = {borrow ? acc_i[2*W-2:W-1] : trial[W-1:0],
                   acc_i[W-2:0], ~borrow};
endmodule

// File: rtl/div_fix.sv
module div_fix #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] acc_i,
  input  logic           neg_q_i,
  input  logic           neg_r_i,
  input  logic           dz_i,
  input  logic [W-1:0]   dvd_i,
  output logic [W-1:0]   hi_o,
  output logic [W-1:0]   lo_o
);
  logic [W-1:0] q_mag, r_mag;
  assign q_mag = acc_i[W-1:0];
  assign r_mag = acc_i[2*W-1:W];

  always_comb begin
    if (dz_i) begin
      lo_o = '1;
      hi_o = dvd_i;
    end else begin
      lo_o = neg_q_i ? -q_mag : q_mag;
      hi_o = neg_r_i ? -r_mag : r_mag;
    end
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         dz_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  import div_pkg::*;

  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  div_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [2*W-1:0] acc_q, acc_nxt;
  logic [W-1:0]  dvs_q, dvd_q;
  logic          nq_q, nr_q, dz_q;
  logic          done_q, dzo_q;
  logic [W-1:0]  hi_q, lo_q;

  logic [W-1:0]  dvd_mag, dvs_mag;
  logic          neg_q, neg_r;
  logic [W-1:0]  hi_fix, lo_fix;
  logic          accept;

  assign accept = start_i && (state_q == ST_IDLE);

  div_prep #(.W(W)) u_prep (
    .dvd_i     (dividend_i),
    .dvs_i     (divisor_i),
    .sgn_i     (signed_i),
    .dvd_mag_o (dvd_mag),
    .dvs_mag_o (dvs_mag),
    .neg_q_o   (neg_q),
    .neg_r_o   (neg_r)
  );

  div_step #(.W(W)) u_step (
    .acc_i (acc_q),
    .dvs_i (dvs_q),
    .acc_o (acc_nxt)
  );

  div_fix #(.W(W)) u_fix (
    .acc_i   (acc_q),
    .neg_q_i (nq_q),
    .neg_r_i (nr_q),
    .dz_i    (dz_q),
    .dvd_i   (dvd_q),
    .hi_o    (hi_fix),
    .lo_o    (lo_fix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      acc_q   <= '0;
      dvs_q   <= '0;
      dvd_q   <= '0;
      nq_q    <= 1'b0;
      nr_q    <= 1'b0;
      dz_q    <= 1'b0;
      done_q  <= 1'b0;
      dzo_q   <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            acc_q   <= {{W{1'b0}}, dvd_mag};
            dvs_q   <= dvs_mag;
            dvd_q   <= dividend_i;
            nq_q    <= neg_q;
            nr_q    <= neg_r;
            dz_q    <= (divisor_i == '0);
            cnt_q   <= '0;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          acc_q <= acc_nxt;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_FIX;
        end
        ST_FIX: begin
          hi_q    <= hi_fix;
          lo_q    <= lo_fix;
          dzo_q   <= dz_q;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign dz_o   = dzo_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
endmodule

// File: rtl/seq_divider_chk.sv
module seq_divider_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         signed_i,
  input logic [W-1:0] dividend_i,
  input logic [W-1:0] divisor_i,
  input logic         busy_o,
  input logic         done_o,
  input logic         dz_o,
  input logic [W-1:0] hi_o,
  input logic [W-1:0] lo_o
);
  localparam int LW = $clog2(W + 4) + 1;

  logic [LW-1:0] lat_q;
  logic [W-1:0]  cap_a, cap_b;
  logic          cap_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      cap_a <= '0;
      cap_b <= '0;
      cap_s <= 1'b0;
    end else if (start_i && !busy_o) begin
      lat_q <= '0;
      cap_a <= dividend_i;
      cap_b <= divisor_i;
      cap_s <= signed_i;
    end else if (busy_o) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  // R5
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == LW'(W + 1)));

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2
  unsigned_ident_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !cap_s && cap_b != '0) |->
      (({{W{1'b0}}, lo_o} * {{W{1'b0}}, cap_b} + {{W{1'b0}}, hi_o}) == {{W{1'b0}}, cap_a})
      && (hi_o < cap_b));

  // R4
  rem_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cap_s && cap_b != '0 && hi_o != '0) |-> (hi_o[W-1] == cap_a[W-1]));

  // R8
  zero_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((dz_o == (cap_b == '0)) && (!dz_o || (lo_o == '1 && hi_o == cap_a))));

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> (done_o || ($stable(hi_o) && $stable(lo_o) && $stable(dz_o))));
endmodule

bind seq_divider seq_divider_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .signed_i   (signed_i),
  .dividend_i (dividend_i),
  .divisor_i  (divisor_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .dz_o       (dz_o),
  .hi_o       (hi_o),
  .lo_o       (lo_o)
);

// File: tb/seq_divider_test.sv
module seq_divider_test;
  localparam int W = 32;
  localparam int LAT = W + 1;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         signed_i = 1'b0;
  logic [W-1:0] dividend_i = '0;
  logic [W-1:0] divisor_i = '0;
  logic         busy_o, done_o, dz_o;
  logic [W-1:0] hi_o, lo_o;

  seq_divider #(.W(W)) uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .signed_i   (signed_i),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .dz_o       (dz_o),
    .hi_o       (hi_o),
    .lo_o       (lo_o)
  );

  always #5 clk_i = ~clk_i;

  typedef struct {
    logic [W-1:0] hi;
    logic [W-1:0] lo;
    logic         dz;
    int           due;
    string        req;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_run = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                 input logic s, input string req);
    exp_t e;
    logic signed [W-1:0] sa, sb;
    sa = a;
    sb = b;
    e.req = req;
    e.due = 0;
    if (b == '0) begin
      e.lo = '1; e.hi = a; e.dz = 1'b1;
    end else if (s && a == {1'b1, {(W-1){1'b0}}} && b == '1) begin
      e.lo = a; e.hi = '0; e.dz = 1'b0;
    end else if (s) begin
      e.lo = sa / sb; e.hi = sa % sb; e.dz = 1'b0;
    end else begin
      e.lo = a / b; e.hi = a % b; e.dz = 1'b0;
    end
    return e;
  endfunction

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic s, input string req);
    exp_t e;
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    dividend_i = a;
    divisor_i  = b;
    signed_i   = s;
    start_i    = 1'b1;
    e = model(a, b, s, req);
    e.due = cyc + 1 + LAT;
    exp_q.push_back(e);
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // monitor
  bit prev_done = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      if (prev_done && done_o) check(1'b0, "R6", "done width", 32'd2, 32'd1);
      if (done_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(cyc == e.due, "R5", {e.req, " latency"}, W'(cyc), W'(e.due));
          check(lo_o == e.lo, e.req, "quotient", lo_o, e.lo);
          check(hi_o == e.hi, e.req, "remainder", hi_o, e.hi);
          check(dz_o == e.dz, "R8", {e.req, " dz flag"}, W'(dz_o), W'(e.dz));
        end
      end
      prev_done <= done_o;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : driver
    logic [W-1:0] x;
    logic [W-1:0] y;
    int held;
    repeat (3) @(negedge clk_i);
    // R1
    check(!busy_o && !done_o && !dz_o, "R1", "flags", {29'd0, busy_o, done_o, dz_o}, '0);
    check(hi_o == '0 && lo_o == '0, "R1", "results", hi_o | lo_o, '0);
    rst_ni = 1'b1;

    run_op(32'd7, 32'd3, 1'b0, "R2");
    run_op(32'd100, 32'd7, 1'b0, "R2");
    run_op(32'hFFFF_FFFF, 32'd1, 1'b0, "R2");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R2");
    run_op(32'd5, 32'd10, 1'b0, "R2");
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, "R2");
    run_op(32'd7, -32'sd3, 1'b1, "R3");
    run_op(-32'sd7, -32'sd3, 1'b1, "R3");
    run_op(-32'sd7, 32'd3, 1'b1, "R4");
    run_op(-32'sd100, 32'd7, 1'b1, "R4");
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R9");
    run_op(32'd1234, 32'd0, 1'b0, "R8");
    run_op(-32'sd55, 32'd0, 1'b1, "R8");

    // R7: start during an operation must be ignored
    run_op(32'd1000, 32'd9, 1'b0, "R7");
    repeat (5) @(negedge clk_i);
    dividend_i = 32'd77; divisor_i = 32'd0; signed_i = 1'b1; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o, "R7", "busy after ignored start", W'(busy_o), 32'd1);

    // R10: results hold while idle
    while (busy_o || exp_q.size() != 0) @(negedge clk_i);
    held = 0;
    repeat (10) begin
      @(negedge clk_i);
      if (hi_o != 32'd1 || lo_o != 32'd111) held++;
    end
    check(held == 0, "R10", "hold while idle", W'(held), '0);

    // pseudo-random mix, R2 and R3/R4
    x = 32'h1234_5678;
    for (int i = 0; i < 24; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      y = x >> (i % 29);
      if (y == '0) y = 32'd3;
      run_op(x, y, i[0], i[0] ? "R3" : "R2");
    end

    while (busy_o || exp_q.size() != 0) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    check(!done_o, "R6", "no trailing done", W'(done_o), '0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule